// File: doc/BRIEF.md
# Microcode Store Write Port with Auto-Stepping Address

This block sits in front of a writeable microcode control store and gives it a small register-bus front end. There are three registers. A 16-bit address register splits into a 13-bit word address in bits 12:0, a 2-bit piece counter in bits 14:13 and a plain storage bit 15. A 32-bit data register holds the most recent data write. A 13-bit break register holds a microbreak address. The control store is wide, so one microword spans several 32-bit pieces. Every data write advances the piece counter, and when the counter reaches its top value the word address moves on. Software can therefore load a run of microwords by writing the address once and then streaming data writes.

Each register has its own write strobe, and all three share one write-data bus. Reads are combinational and chosen by a 2-bit select code. The address register and the data register are also driven straight out to the store array, which lies outside this block. Every port is a plain control or status pin. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `ucs_wport`

## Requirements
- R1: While reset is low and after it is released, the address, data and break registers read as zero, and `cs_addr` and `cs_data` are zero.
- R2: A write with `wr_stb[0]` (address) stores `wdata[15:0]` in the address register. Read select code 0 returns it zero-extended to 32 bits.
- R3: A write with `wr_stb[1]` (data) and without `wr_stb[0]` stores all 32 bits of `wdata` in the data register, which is seen on `cs_data`. It also adds one, modulo 4, to the piece counter in address bits 14:13.
- R4: After that step, if the new counter value is 3, the word address in bits 12:0 increases by one and wraps from 0x1FFF to 0. Otherwise the word address is unchanged.
- R5: Address bit 15 is changed only by an address write, never by a step.
- R6: Read select code 1 (data) always returns 0x000000FF, whatever was last written.
- R7: A write with `wr_stb[2]` (break) keeps only `wdata[12:0]`. Read select code 2 returns those 13 bits with zeros above them.
- R8: Read select code 3 returns zero.
- R9: When the address and data strobes are asserted in the same cycle, the address register takes `wdata[15:0]` unchanged and no step happens. The data register still captures `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 3 | Write strobes: bit 0 address, bit 1 data, bit 2 break |
| wdata | input | 32 | Shared write data |
| rd_sel | input | 2 | Read select code: 0 address, 1 data, 2 break, 3 none |
| rdata | output | 32 | Combinational read data for `rd_sel` |
| cs_addr | output | 16 | Current address register, to the store array |
| cs_data | output | 32 | Current data register, to the store array |

## Verification
An address write and a data write can land on the same edge. In that case the load and the auto-step compete for the address register. The bench provokes this with random strobe patterns that often assert both bits, and with a directed case where the counter is at 2 and the word address is at 0x1FFF, so that a step would visibly change both fields. It judges the result by comparing `cs_addr` with the raw `wdata[15:0]`, and it confirms that `cs_data` still took the written word in that same cycle.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int ADDR_W   = 16;
  localparam int WORD_W   = 13;
  localparam int PIECE_W  = 2;
  localparam int DATA_W   = 32;
  localparam int BRK_W    = 13;
  localparam int SEL_W    = 2;
  localparam int STB_W    = 3;
  localparam logic [DATA_W-1:0] DATA_RD_CONST = 32'h0000_00FF;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_BRK  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  localparam int STB_ADDR = 0;
  localparam int STB_DATA = 1;
  localparam int STB_BRK  = 2;
endpackage

// File: rtl/ucs_addr_reg.sv
module ucs_addr_reg #(
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 13,
  parameter int PIECE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] q
);
  localparam int PIECE_LO = WORD_W;
  localparam int PIECE_HI = WORD_W + PIECE_W - 1;
  localparam int TOP_LO   = WORD_W + PIECE_W;
  localparam logic [PIECE_W-1:0] PIECE_MAX = {PIECE_W{1'b1}};

  logic [WORD_W-1:0]  word_q, word_nx;
  logic [PIECE_W-1:0] piece_q, piece_nx, piece_inc;
  logic [ADDR_W-1:0]  q_nx;

  assign word_q  = q[WORD_W-1:0];
  assign piece_q = q[PIECE_HI:PIECE_LO];
  assign piece_inc = piece_q + 1'b1;

  always_comb begin
    piece_nx = piece_inc;
    word_nx  = (piece_inc == PIECE_MAX) ? word_q + 1'b1 : word_q;
    if (load) begin
      q_nx = load_val;
    end else if (step) begin
      q_nx = q;
      q_nx[WORD_W-1:0]        = word_nx;
      q_nx[PIECE_HI:PIECE_LO] = piece_nx;
    end else begin
      q_nx = q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  AST_PIECE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (q[PIECE_HI:PIECE_LO] == $past(q[PIECE_HI:PIECE_LO]) + 1'b1)); // R3
  AST_WORD_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && q[PIECE_HI:PIECE_LO] == PIECE_MAX - 1'b1) |=> (q[WORD_W-1:0] == $past(q[WORD_W-1:0]) + 1'b1)); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && q[PIECE_HI:PIECE_LO] != PIECE_MAX - 1'b1) |=> $stable(q[WORD_W-1:0])); // R4
  AST_TOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> $stable(q[ADDR_W-1:TOP_LO])); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val))); // R9
endmodule

// File: rtl/ucs_mask_reg.sv
module ucs_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d))); // R3
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R7
endmodule

// File: rtl/ucs_rd_mux.sv
module ucs_rd_mux
  import ucs_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [BRK_W-1:0]  brk_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    unique case (rd_sel_e'(sel))
      SEL_ADDR: rdata = DATA_W'(addr_q);
      SEL_DATA: rdata = DATA_RD_CONST;
      SEL_BRK:  rdata = DATA_W'(brk_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/ucs_wport.sv
module ucs_wport
  import ucs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STB_W-1:0]  wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] cs_addr,
  output logic [DATA_W-1:0] cs_data
);
  logic [BRK_W-1:0] brk_q;

  ucs_addr_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PIECE_W(PIECE_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(wr_stb[STB_ADDR]), .step(wr_stb[STB_DATA]),
    .load_val(wdata[ADDR_W-1:0]), .q(cs_addr)
  );

  ucs_mask_reg #(.W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .we(wr_stb[STB_DATA]), .d(wdata), .q(cs_data)
  );

  ucs_mask_reg #(.W(BRK_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .we(wr_stb[STB_BRK]), .d(wdata[BRK_W-1:0]), .q(brk_q)
  );

  ucs_rd_mux u_mux (.sel(rd_sel), .addr_q(cs_addr), .brk_q(brk_q), .rdata(rdata));

  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (cs_addr == '0 && cs_data == '0)); // R1
  AST_NO_STRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[STB_ADDR] == 1'b0 && wr_stb[STB_DATA] == 1'b0) |=> $stable(cs_addr)); // R2
endmodule

// File: tb/ucs_wport_tb.sv
module ucs_wport_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  wr_stb = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rdata;
  logic [15:0] cs_addr;
  logic [31:0] cs_data;

  int total = 0, bad = 0;
  logic [15:0] m_addr;
  logic [31:0] m_data;
  logic [12:0] m_brk;

  ucs_wport u_dut (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wdata(wdata),
                   .rd_sel(rd_sel), .rdata(rdata), .cs_addr(cs_addr), .cs_data(cs_data));

  always #5 clk = ~clk;

  function automatic logic [15:0] addr_next(logic [15:0] a, logic [2:0] s, logic [31:0] d);
    logic [1:0] p;
    logic [12:0] w;
    if (s[0]) return d[15:0];
    if (!s[1]) return a;
    p = a[14:13] + 2'd1;
    w = (p == 2'd3) ? a[12:0] + 13'd1 : a[12:0];
    return {a[15], p, w};
  endfunction

  function automatic logic [31:0] read_exp(logic [1:0] s);
    case (s)
      2'd0: return {16'h0, m_addr};
      2'd1: return 32'hFF;
      2'd2: return {19'h0, m_brk};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(logic both);
    chk(both ? "R9 addr" : "R3 piece", {30'h0, cs_addr[14:13]}, {30'h0, m_addr[14:13]});
    chk(both ? "R9 word" : "R4 word", {19'h0, cs_addr[12:0]}, {19'h0, m_addr[12:0]});
    chk("R5 top", {31'h0, cs_addr[15]}, {31'h0, m_addr[15]});
    chk("R3 data", cs_data, m_data);
    for (int s = 0; s < 4; s++) begin
      rd_sel = s[1:0];
      #1;
      case (s)
        0: chk("R2 read addr", rdata, read_exp(2'd0));
        1: chk("R6 read data", rdata, read_exp(2'd1));
        2: chk("R7 read brk", rdata, read_exp(2'd2));
        default: chk("R8 read none", rdata, read_exp(2'd3));
      endcase
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    wr_stb = s;
    wdata = d;
    @(posedge clk);
    m_addr = addr_next(m_addr, s, d);
    if (s[1]) m_data = d;
    if (s[2]) m_brk = d[12:0];
    @(negedge clk);
    wr_stb = '0;
    check_all(s[0] && s[1]);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    m_addr = '0; m_data = '0; m_brk = '0;
    wr_stb = 3'b111; wdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_stb = '0;
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 addr", {16'h0, cs_addr}, 32'h0);
    chk("R1 data", cs_data, 32'h0);
    rd_sel = 2'd2; #1;
    chk("R1 brk", rdata, 32'h0);

    // Directed: address load then four data writes across one word
    wr(3'b001, 32'h0000_8005);
    for (int i = 0; i < 4; i++) wr(3'b010, 32'hA5A5_0000 + i);
    // Directed: word wrap 0x1FFF with counter at 2 and bit 15 set
    wr(3'b001, 32'h0000_DFFF);
    wr(3'b010, 32'h1234_5678);
    // Directed: same-cycle address+data with counter at 2
    wr(3'b001, 32'h0000_5FFF);
    wr(3'b011, 32'hCAFE_5FFF);
    // Directed: break masking
    wr(3'b100, 32'hFFFF_FFFF);
    wr(3'b100, 32'h0000_2001);

    for (int n = 0; n < 400; n++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0) s = 3'b010;
      wr(s, $urandom());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule